// File: doc/BRIEF.md
# JTAG Bulk Shift and Verify Engine

This block turns a byte stream of commands into JTAG activity. One shift command carries many data bytes. Each byte goes out on TDI, least significant bit first, while the block drives TCK from the system clock through a programmable divider. Every TDO bit is captured on the rising edge of TCK. In verify mode the captured byte is checked here, under a mask, against an expected byte taken from the same command. The captured data never travels back upstream.

A poll command rescans one byte until a chosen TDO bit reads zero, and the next queued command follows at once. Mismatches and poll timeouts are recorded in sticky flags. The failure is reported right away on a one-byte status stream. Otherwise status leaves the block only when a status-request command asks for it. Commands pass through a receive FIFO, so a producer can queue several packets before it stalls.

Both streams use valid/ready. A command byte is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high, and the producer must hold the byte until then. The engine holds `sts_valid` and `sts_data` steady until the consumer raises `sts_ready`.

Top module: `jtag_shift_engine`

## Requirements
- R1: The command FIFO holds up to FIFO_DEPTH (256) bytes. `cmd_ready` is high whenever fewer than that many bytes are buffered, and accepted bytes are executed in arrival order.
- R2: TCK idles low. Each byte gives eight TCK pulses, with TCK high for clk_div+1 clocks and low for clk_div+1 clocks. TDI presents bit 0 first and changes only while TCK is low.
- R3: Shift command 0x01 is followed by a flags byte, then a length byte L, which means L+1 data bytes. Flags bit 0 is the exit flag and bit 1 selects verify. TMS stays low, except on the eighth bit of the last byte when the exit flag is set.
- R4: In verify mode each data byte is sent as three bytes: TDI, then expected, then mask. A byte fails when (captured XOR expected) AND mask is non-zero. A failure stops the shifting and emits status 0x81 without waiting for a request. Differences in bits where the mask is zero have no effect.
- R5: A shift without the verify flag sends only TDI bytes and produces no status byte.
- R6: Poll command 0x02 is followed by a bit index (bits 2:0), the scan count low byte, the scan count high byte, a wait byte and a TDI byte. The block rescans, pausing for the wait value in clocks between scans, until captured bit[index] is 0. It then continues with the next command and emits no status.
- R7: If the selected bit is still 1 after the given number of scans (0 behaves as 1), the poll times out and emits status 0x42.
- R8: The status byte is {mismatch, timeout, 4'b0, opcode[1:0]}, where the opcode field is 01 for shift and 10 for poll. Status request 0x03 emits the current byte and clears it, so a request with nothing recorded returns 0x00.
- R9: After a failure, later commands are parsed and thrown away without any TCK activity until a status request. Normal execution resumes after that request.
- R10: While `sts_valid` is high and `sts_ready` is low, `sts_valid` and `sts_data` stay unchanged.
- R11: Any other opcode byte is consumed alone and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | 8 | TCK half period minus one, in clocks |
| cmd_data | input | 8 | Command stream byte |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | FIFO can accept a byte |
| sts_data | output | 8 | Status byte |
| sts_valid | output | 1 | Status byte valid |
| sts_ready | input | 1 | Consumer takes the status byte |
| jtag_tck | output | 1 | JTAG clock |
| jtag_tms | output | 1 | JTAG mode select |
| jtag_tdi | output | 1 | JTAG data toward the target |
| jtag_tdo | input | 1 | JTAG data from the target |

## Verification
The assertions assume that `clk_div` is not changed while a byte is being shifted. They also assume that the command producer holds each byte until it is accepted. They expect that `jtag_tdo` settles before the clock edge on which TCK rises. The bench changes `clk_div` only while the engine is idle. It drives every input at the falling system clock edge, and it keeps `cmd_valid` and `cmd_data` asserted until `cmd_ready` has been seen high. Its TDO model changes the bit only just after a TCK rise, which leaves the whole low phase for it to settle.

// File: rtl/jse_pkg.sv
package jse_pkg;
  localparam logic [7:0] OP_SHIFT  = 8'h01;
  localparam logic [7:0] OP_POLL   = 8'h02;
  localparam logic [7:0] OP_STATUS = 8'h03;

  typedef enum logic [3:0] {
    S_OP, S_SFLG, S_SLEN, S_STDI, S_SEXP, S_SMSK, S_SRUN,
    S_PSEL, S_PCLO, S_PCHI, S_PWT, S_PTDI, S_PRUN, S_PGAP
  } state_t;

  typedef struct packed {
    logic       mism;
    logic       tmo;
    logic [1:0] op;
  } sticky_t;
endpackage

// File: rtl/jse_fifo.sv
module jse_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [W-1:0]  out_data,
  output logic          out_valid,
  input  logic          pop,
  output logic [CW-1:0] count
);
  timeunit 1ns; timeprecision 100ps;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push, take;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;
  assign take      = pop && out_valid;

  always_ff @(posedge clk) if (push) mem[wp] <= in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (take) rp <= rp + AW'(1);
      if (push && !take) count <= count + CW'(1);
      else if (take && !push) count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/jse_bitshift.sv
module jse_bitshift #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div,
  input  logic            start,
  input  logic [7:0]      tx,
  input  logic            last_tms,
  input  logic            tdo,
  output logic            busy,
  output logic            done,
  output logic [7:0]      rx,
  output logic            tck,
  output logic            tms,
  output logic            tdi
);
  timeunit 1ns; timeprecision 100ps;

  logic [DIVW-1:0] cnt;
  logic [2:0]      idx;
  logic [7:0]      sh;
  logic            ex;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; rx <= '0; tck <= 1'b0; tms <= 1'b0;
      tdi <= 1'b0; cnt <= '0; idx <= '0; sh <= '0; ex <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; sh <= tx; ex <= last_tms; idx <= '0; cnt <= '0;
          tdi <= tx[0]; tms <= 1'b0;
        end
      end else if (cnt != div) begin
        cnt <= cnt + DIVW'(1);
      end else begin
        cnt <= '0;
        if (!tck) begin
          tck     <= 1'b1;
          rx[idx] <= tdo;
        end else begin
          tck <= 1'b0;
          if (idx == 3'd7) begin
            busy <= 1'b0; done <= 1'b1; tms <= 1'b0;
          end else begin
            idx <= idx + 3'd1;
            tdi <= sh[idx + 3'd1];
            tms <= ex && (idx == 3'd6);
          end
        end
      end
    end
  end
endmodule

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine #(
  parameter int FIFO_DEPTH = 256,
  parameter int DIVW       = 8,
  localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] clk_div,
  input  logic [7:0]      cmd_data,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  output logic [7:0]      sts_data,
  output logic            sts_valid,
  input  logic            sts_ready,
  output logic            jtag_tck,
  output logic            jtag_tms,
  output logic            jtag_tdi,
  input  logic            jtag_tdo
);
  timeunit 1ns; timeprecision 100ps;
  import jse_pkg::*;

  logic [7:0]    f_data;
  logic          f_valid, take;
  logic [CW-1:0] f_cnt;
  logic          bs_go, bs_last, bs_busy, bs_done;
  logic [7:0]    bs_rx;

  state_t     st;
  sticky_t    sticky;
  logic       failed, fail_pend, exitf, verify;
  logic [7:0] nleft, tdi_b, exp_b, msk_b, pwait, gapc;
  logic [2:0] psel;
  logic [15:0] pcnt;
  logic       rd_state, stat_blk;

  jse_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .in_data(cmd_data), .in_valid(cmd_valid),
    .in_ready(cmd_ready), .out_data(f_data), .out_valid(f_valid),
    .pop(take), .count(f_cnt)
  );

  jse_bitshift #(.DIVW(DIVW)) shift_i (
    .clk(clk), .rst_n(rst_n), .div(clk_div), .start(bs_go), .tx(tdi_b),
    .last_tms(bs_last), .tdo(jtag_tdo), .busy(bs_busy), .done(bs_done),
    .rx(bs_rx), .tck(jtag_tck), .tms(jtag_tms), .tdi(jtag_tdi)
  );

  assign failed   = sticky.mism | sticky.tmo;
  assign bs_last  = (st == S_SRUN) && exitf && (nleft == 8'd0);
  assign rd_state = (st != S_SRUN) && (st != S_PRUN) && (st != S_PGAP);
  assign stat_blk = (st == S_OP) && (f_data == OP_STATUS) && (sts_valid || fail_pend);
  assign take     = f_valid && rd_state && !stat_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OP; sticky <= '0; fail_pend <= 1'b0; exitf <= 1'b0; verify <= 1'b0;
      nleft <= '0; tdi_b <= '0; exp_b <= '0; msk_b <= '0; pwait <= '0; gapc <= '0;
      psel <= '0; pcnt <= '0; bs_go <= 1'b0; sts_valid <= 1'b0; sts_data <= '0;
    end else begin
      bs_go <= 1'b0;
      if (sts_valid && sts_ready) sts_valid <= 1'b0;
      if (fail_pend && !sts_valid) begin
        sts_valid <= 1'b1;
        sts_data  <= {sticky.mism, sticky.tmo, 4'b0, sticky.op};
        fail_pend <= 1'b0;
      end
      case (st)
        S_OP: if (take) begin
          if (f_data == OP_SHIFT) st <= S_SFLG;
          else if (f_data == OP_POLL) st <= S_PSEL;
          else if (f_data == OP_STATUS) begin
            sts_valid <= 1'b1;
            sts_data  <= {sticky.mism, sticky.tmo, 4'b0, sticky.op};
            sticky    <= '0;
          end
        end
        S_SFLG: if (take) begin exitf <= f_data[0]; verify <= f_data[1]; st <= S_SLEN; end
        S_SLEN: if (take) begin nleft <= f_data; st <= S_STDI; end
        S_STDI, S_SMSK: if (take) begin
          if (st == S_STDI) tdi_b <= f_data; else msk_b <= f_data;
          if (st == S_STDI && verify) st <= S_SEXP;
          else if (!failed) begin bs_go <= 1'b1; st <= S_SRUN; end
          else if (nleft == 8'd0) st <= S_OP;
          else begin nleft <= nleft - 8'd1; st <= S_STDI; end
        end
        S_SEXP: if (take) begin exp_b <= f_data; st <= S_SMSK; end
        S_SRUN: if (bs_done) begin
          if (verify && (((bs_rx ^ exp_b) & msk_b) != 8'd0)) begin
            sticky.mism <= 1'b1; sticky.op <= 2'b01; fail_pend <= 1'b1;
          end
          if (nleft == 8'd0) st <= S_OP;
          else begin nleft <= nleft - 8'd1; st <= S_STDI; end
        end
        S_PSEL: if (take) begin psel <= f_data[2:0]; st <= S_PCLO; end
        S_PCLO: if (take) begin pcnt[7:0] <= f_data; st <= S_PCHI; end
        S_PCHI: if (take) begin pcnt[15:8] <= f_data; st <= S_PWT; end
        S_PWT:  if (take) begin pwait <= f_data; st <= S_PTDI; end
        S_PTDI: if (take) begin
          tdi_b <= f_data;
          if (failed) st <= S_OP;
          else begin bs_go <= 1'b1; st <= S_PRUN; end
        end
        S_PRUN: if (bs_done) begin
          if (!bs_rx[psel]) st <= S_OP;
          else if (pcnt <= 16'd1) begin
            sticky.tmo <= 1'b1; sticky.op <= 2'b10; fail_pend <= 1'b1; st <= S_OP;
          end else begin
            pcnt <= pcnt - 16'd1; gapc <= pwait; st <= S_PGAP;
          end
        end
        S_PGAP: begin
          if (gapc == 8'd0) begin bs_go <= 1'b1; st <= S_PRUN; end
          else gapc <= gapc - 8'd1;
        end
        default: st <= S_OP;
      endcase
    end
  end
endmodule

// File: rtl/jse_checker.sv
module jse_checker #(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [CW-1:0] fifo_cnt,
  input logic          sts_valid,
  input logic          sts_ready,
  input logic [7:0]    sts_data,
  input logic          tck,
  input logic          tms,
  input logic          tdi,
  input logic          failed
);
  timeunit 1ns; timeprecision 100ps;

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |-> fifo_cnt < CW'(DEPTH));

  p_tdi_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tdi) |-> !tck);

  p_tms_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tms) |-> !tck);

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    failed && $past(failed) |-> !$rose(tck));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid && !sts_ready |=> sts_valid && $stable(sts_data));
endmodule

bind jtag_shift_engine jse_checker #(.DEPTH(FIFO_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .fifo_cnt(f_cnt), .sts_valid(sts_valid), .sts_ready(sts_ready),
  .sts_data(sts_data), .tck(jtag_tck), .tms(jtag_tms), .tdi(jtag_tdi),
  .failed(failed)
);

// File: tb/jtag_shift_engine_tb_top.sv
module jtag_shift_engine_tb_top;
  timeunit 1ns; timeprecision 100ps;

  localparam int DEPTH = 256;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, cmd_valid, cmd_ready, sts_valid, sts_ready;
  logic       jtag_tck, jtag_tms, jtag_tdi, jtag_tdo;
  logic [7:0] clk_div, cmd_data, sts_data;

  jtag_shift_engine #(.FIFO_DEPTH(DEPTH), .DIVW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .cmd_data(cmd_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .sts_data(sts_data),
    .sts_valid(sts_valid), .sts_ready(sts_ready), .jtag_tck(jtag_tck),
    .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi), .jtag_tdo(jtag_tdo)
  );

  int   checks = 0, failures = 0, hi_cnt = 0;
  bit   finished = 0;
  logic [1:0] exp_q[$];
  bit         tdo_q[$];
  logic [7:0] sts_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic send(input logic [7:0] b);
    cmd_data = b; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expect_byte(input logic [7:0] tdi_b, input logic [7:0] tdo_b,
                             input bit exit_b);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back({exit_b && (i == 7), tdi_b[i]});
      tdo_q.push_back(tdo_b[i]);
    end
    jtag_tdo = tdo_q[0];
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || sts_q.size() != 0) && n < 20000) begin
      @(negedge clk); n++;
    end
    repeat (30) @(negedge clk);
  endtask

  // scoreboard monitor for the JTAG side
  always @(posedge jtag_tck) begin
    logic [1:0] e;
    if (exp_q.size() == 0) chk(0, "R9", "unexpected TCK pulse", 1, 0);
    else begin
      e = exp_q.pop_front();
      chk(jtag_tdi == e[0], "R2", "TDI bit order", int'(jtag_tdi), int'(e[0]));
      chk(jtag_tms == e[1], "R3", "TMS on bit", int'(jtag_tms), int'(e[1]));
    end
    if (tdo_q.size() != 0) void'(tdo_q.pop_front());
    jtag_tdo = (tdo_q.size() != 0) ? tdo_q[0] : 1'b0;
  end

  always @(posedge clk) if (jtag_tck) hi_cnt++;
  always @(negedge jtag_tck) begin
    chk(hi_cnt == int'(clk_div) + 1, "R2", "TCK high time", hi_cnt, int'(clk_div) + 1);
    hi_cnt = 0;
  end

  // scoreboard monitor for the status stream
  always @(posedge clk) begin
    if (rst_n && sts_valid && sts_ready) begin
      if (sts_q.size() == 0) chk(0, "R8", "unexpected status byte", int'(sts_data), 0);
      else begin
        logic [7:0] e;
        e = sts_q.pop_front();
        chk(sts_data == e, "R8", "status byte value", int'(sts_data), int'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0; sts_ready = 1'b1;
    clk_div = 8'd1; jtag_tdo = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);
    chk(sts_valid == 1'b0, "R8", "no status after reset", int'(sts_valid), 0);
    chk(jtag_tck == 1'b0 && jtag_tms == 1'b0, "R2", "TCK/TMS idle low",
        int'({jtag_tck, jtag_tms}), 0);

    // R5 write-only multi-byte shift, R2 LSB first
    expect_byte(8'hA5, 8'h00, 0); expect_byte(8'h3C, 8'h00, 0); expect_byte(8'hF0, 8'h00, 0);
    send(8'h01); send(8'h00); send(8'h02); send(8'hA5); send(8'h3C); send(8'hF0);
    drain();
    chk(exp_q.size() == 0, "R5", "write shift done", exp_q.size(), 0);

    // R3 exit flag raises TMS on the last bit
    expect_byte(8'h81, 8'h00, 1);
    send(8'h01); send(8'h01); send(8'h00); send(8'h81);
    drain();

    // R2 slower divider
    clk_div = 8'd3;
    expect_byte(8'h6E, 8'h00, 0);
    send(8'h01); send(8'h00); send(8'h00); send(8'h6E);
    drain();
    clk_div = 8'd1;

    // R4 masked-out difference is ignored
    expect_byte(8'h0F, 8'hA5, 0);
    send(8'h01); send(8'h02); send(8'h00); send(8'h0F); send(8'hAA); send(8'hF0);
    drain();
    chk(sts_valid == 1'b0, "R4", "masked difference gives no status", int'(sts_valid), 0);

    // R6 poll clears on third scan, next command follows
    expect_byte(8'h00, 8'h08, 0); expect_byte(8'h00, 8'h08, 0); expect_byte(8'h00, 8'h00, 0);
    expect_byte(8'h55, 8'h00, 0);
    send(8'h02); send(8'h03); send(8'h05); send(8'h00); send(8'h04); send(8'h00);
    send(8'h01); send(8'h00); send(8'h00); send(8'h55);
    drain();
    chk(exp_q.size() == 0, "R6", "poll then shift completed", exp_q.size(), 0);

    // R8 status request with nothing recorded
    sts_q.push_back(8'h00);
    send(8'h03);
    drain();
    chk(sts_q.size() == 0, "R8", "clean status returned", sts_q.size(), 0);

    // R4 mismatch on second byte; third byte never shifted
    expect_byte(8'h11, 8'h22, 0); expect_byte(8'h33, 8'h45, 0);
    sts_q.push_back(8'h81);
    send(8'h01); send(8'h02); send(8'h02);
    send(8'h11); send(8'h22); send(8'hFF);
    send(8'h33); send(8'h44); send(8'h0F);
    send(8'h77); send(8'h77); send(8'hFF);
    drain();
    chk(sts_q.size() == 0, "R4", "mismatch status without request", sts_q.size(), 0);

    // R9 discarded commands: no TCK, no status
    send(8'h01); send(8'h00); send(8'h00); send(8'hFF);
    send(8'h02); send(8'h00); send(8'h01); send(8'h00); send(8'h00); send(8'h00);
    send(8'h55);
    drain();
    chk(sts_valid == 1'b0, "R9", "no status while discarding", int'(sts_valid), 0);
    sts_q.push_back(8'h81);
    send(8'h03);
    drain();
    sts_q.push_back(8'h00);
    send(8'h03);
    drain();
    chk(sts_q.size() == 0, "R8", "sticky cleared by request", sts_q.size(), 0);
    expect_byte(8'h3A, 8'h00, 0);
    send(8'h01); send(8'h00); send(8'h00); send(8'h3A);
    drain();
    chk(exp_q.size() == 0, "R9", "execution resumes after request", exp_q.size(), 0);

    // R7 poll timeout after exactly three scans
    expect_byte(8'hC3, 8'h01, 0); expect_byte(8'hC3, 8'h01, 0); expect_byte(8'hC3, 8'h01, 0);
    sts_q.push_back(8'h42);
    send(8'h02); send(8'h00); send(8'h03); send(8'h00); send(8'h00); send(8'hC3);
    drain();
    chk(sts_q.size() == 0, "R7", "timeout status", sts_q.size(), 0);
    sts_q.push_back(8'h42);
    send(8'h03);
    drain();

    // R11 unknown opcodes ignored
    expect_byte(8'h96, 8'h00, 0);
    send(8'h00); send(8'h7E); send(8'hC4);
    send(8'h01); send(8'h00); send(8'h00); send(8'h96);
    drain();
    chk(exp_q.size() == 0 && sts_valid == 1'b0, "R11", "unknown opcodes no effect",
        exp_q.size(), 0);

    // R1 FIFO depth, R10 status hold under back-pressure
    sts_ready = 1'b0;
    send(8'h03); send(8'h03);
    repeat (5) @(negedge clk);
    chk(sts_valid == 1'b1 && sts_data == 8'h00, "R10", "status pending",
        int'({sts_valid, sts_data}), 'h100);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      if (!cmd_ready) break;
      cmd_valid = 1'b1; cmd_data = 8'h00; n++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(n == DEPTH - 1, "R1", "bytes accepted until full", n, DEPTH - 1);
    chk(cmd_ready == 1'b0, "R1", "ready low when full", int'(cmd_ready), 0);
    repeat (20) @(negedge clk);
    chk(sts_valid == 1'b1 && sts_data == 8'h00, "R10", "status held", int'({sts_valid, sts_data}), 'h100);
    sts_q.push_back(8'h00); sts_q.push_back(8'h00);
    sts_ready = 1'b1;
    drain();
    repeat (300) @(negedge clk);
    chk(sts_q.size() == 0, "R10", "held statuses delivered", sts_q.size(), 0);
    chk(cmd_ready == 1'b1, "R1", "FIFO drained", int'(cmd_ready), 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule